// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block decides, every system-clock cycle, which of fifteen differential clock outputs and one internal feedback output may run and which must be parked low/low. A single power-good/power-down pin controls the whole part. Its first high level samples the frequency and PLL-mode straps, holds them in read-only status bits and starts the part. After that, the pin only moves the part into power-down and back out again. Once the part runs, per-output enable bits from three control bytes decide which outputs run.

All start-ups wait for a stabilization interval counted in system-clock cycles. A cold start uses a long count and a wake-up from power-down uses a shorter one. Every gate changes only while the clock it gates is low, so no output ever shows a shortened pulse. The control bytes are written through a simple byte-write port. Their read-back values combine the enable bits, fixed reserved values and the latched strap status.

Top module: `clkout_pd_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all output gates and `pll_on` are 0, every enable bit reads 1 and the latched strap status reads 0, so `cfg_rd0` = 8'h38, `cfg_rd1` = 8'hFF and `cfg_rd2` = 8'hFF.
- R2: On the first high of `pg_pin`, `freq_strap` is captured into `cfg_rd0` bit 0 (1 = 100 MHz, 0 = 133.33 MHz). `mode_strap` is captured into `cfg_rd0` bits 7:6: 2'b11 means high bandwidth, 2'b01 bypass and 2'b00 low bandwidth, and the unused code 2'b10 is stored as 2'b01.
- R3: After the first capture, later changes of the straps and later highs of `pg_pin` leave `cfg_rd0` bits 7:6 and bit 0 unchanged until reset.
- R4: On a cold start, `pll_on` rises 3 cycles after `pg_pin` goes high. The outputs stay parked until STAB_CYC further cycles pass, and run from cycle STAB_CYC+4 on, provided `ref_lvl` is low.
- R5: When `pg_pin` is low, `pll_on` drops 3 cycles later, and the next cycle with `ref_lvl` low parks all of `dif_gate`, `fb_gate`, `dif_out` and `fb_out` to 0.
- R6: When the part leaves power-down, it waits WAKE_CYC cycles instead of STAB_CYC: the outputs run from cycle WAKE_CYC+4 after `pg_pin` goes high.
- R7: While the part runs, an output whose enable bit is 0 is parked and the others keep running. `fb_gate` ignores the enable bits.
- R8: Enable bit positions. Byte 0: bit4 = output 14, bit3 = output 13. Byte 1: bit7 = 5, bit5 = 4, bit4 = 3, bit3 = 2, bit2 = 1, bit1 = 0. Byte 2: bit7 = 12, bit6 = 11, bit5 = 10, bit3 = 9, bit2 = 8, bit1 = 7, bit0 = 6. A write with `cfg_we` high to `cfg_addr` 0, 1 or 2 updates only that byte's enable bits.
- R9: Reserved bits read fixed values: byte 0 bit5 = 1, bits 2:1 = 0; byte 1 bits 6 and 0 = 1; byte 2 bit4 = 1. Writes to those bits, and any write to `cfg_addr` 3, change nothing.
- R10: A gate changes only on a clock edge at which `ref_lvl` is 0. `dif_out`/`fb_out` equal the gate AND `ref_lvl`.
- R11: `pll_on` is 1 during stabilization and while running, and 0 before the first start and in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pin | input | 1 | Power-good (high) / power-down (low) pin |
| freq_strap | input | 1 | Frequency strap, 1 = 100 MHz |
| mode_strap | input | 2 | PLL-mode strap code |
| ref_lvl | input | 1 | Level of the clock being gated |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_addr | input | 2 | Control byte index |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rd0 | output | 8 | Read-back of byte 0 (status and two enables) |
| cfg_rd1 | output | 8 | Read-back of byte 1 |
| cfg_rd2 | output | 8 | Read-back of byte 2 |
| pll_on | output | 1 | PLL run request |
| dif_gate | output | 15 | Per-output run gate |
| fb_gate | output | 1 | Feedback output run gate |
| dif_out | output | 15 | Gated clock levels |
| fb_out | output | 1 | Gated feedback level |

## Verification
The bench builds the block with STAB_CYC = 20 and WAKE_CYC = 8 in place of the millisecond-scale defaults. With these values, the exact cycle at which the outputs start after a cold start and after a wake-up can be checked directly, and the two intervals can be told apart. The short counts leave time for a full enable-map sweep, a gating test with `ref_lvl` held high, a power-down and re-entry, and a second reset within one short run.

// File: rtl/clkout_pd_pkg.sv
`timescale 1ns/1ps
package clkout_pd_pkg;

    localparam int NUM_DIF   = 15;
    localparam int NUM_BYTES = 3;

    typedef enum logic [1:0] {
        PS_WAIT = 2'd0,
        PS_STAB = 2'd1,
        PS_RUN  = 2'd2,
        PS_DOWN = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        PM_LOW  = 2'b00,
        PM_BYP  = 2'b01,
        PM_HIGH = 2'b11
    } pll_mode_e;

    typedef struct packed {
        pll_mode_e mode;
        logic      freq100;
    } strap_t;

    typedef struct packed {
        logic [1:0] byte_idx;
        logic [2:0] bit_idx;
    } en_loc_t;

    // Position of each output's enable bit inside the control bytes.
    function automatic en_loc_t en_loc(input int ch);
        en_loc_t l;
        case (ch)
            0:       l = '{2'd1, 3'd1};
            1:       l = '{2'd1, 3'd2};
            2:       l = '{2'd1, 3'd3};
            3:       l = '{2'd1, 3'd4};
            4:       l = '{2'd1, 3'd5};
            5:       l = '{2'd1, 3'd7};
            6:       l = '{2'd2, 3'd0};
            7:       l = '{2'd2, 3'd1};
            8:       l = '{2'd2, 3'd2};
            9:       l = '{2'd2, 3'd3};
            10:      l = '{2'd2, 3'd5};
            11:      l = '{2'd2, 3'd6};
            12:      l = '{2'd2, 3'd7};
            13:      l = '{2'd0, 3'd3};
            14:      l = '{2'd0, 3'd4};
            default: l = '{2'd3, 3'd0};
        endcase
        return l;
    endfunction

    // Reserved bits that always read as one.
    function automatic logic [7:0] fixed_ones(input int b);
        case (b)
            0:       return 8'h20;
            1:       return 8'h41;
            2:       return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    // Three-way strap decode; the unused code falls back to bypass.
    function automatic pll_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b11:   return PM_HIGH;
            2'b00:   return PM_LOW;
            default: return PM_BYP;
        endcase
    endfunction

endpackage

// File: rtl/pg_sync.sv
`timescale 1ns/1ps
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[STAGES-2:0], din};
    end

    assign dout = shift_q[STAGES-1];
endmodule

// File: rtl/power_seq.sv
`timescale 1ns/1ps
module power_seq
    import clkout_pd_pkg::*;
#(
    parameter int STAB_CYC = 25000,
    parameter int WAKE_CYC = 2500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_s,
    input  logic       freq_strap,
    input  logic [1:0] mode_strap,
    output strap_t     strap,
    output logic       started,
    output logic       pll_on,
    output logic       running
);
    localparam int MAXC = (STAB_CYC > WAKE_CYC) ? STAB_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STAB_LOAD = CW'(STAB_CYC - 1);
    localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYC - 1);

    pwr_state_e    state_q;
    logic [CW-1:0] cnt_q;
    strap_t        strap_q;
    logic          started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_WAIT;
            cnt_q     <= '0;
            strap_q   <= '{PM_LOW, 1'b0};
            started_q <= 1'b0;
        end else begin
            case (state_q)
                PS_WAIT: if (pg_s) begin
                    state_q         <= PS_STAB;
                    cnt_q           <= STAB_LOAD;
                    strap_q.mode    <= decode_mode(mode_strap);
                    strap_q.freq100 <= freq_strap;
                    started_q       <= 1'b1;
                end
                PS_STAB: begin
                    if (!pg_s)            state_q <= PS_DOWN;
                    else if (cnt_q == '0) state_q <= PS_RUN;
                    else                  cnt_q   <= cnt_q - 1'b1;
                end
                PS_RUN: if (!pg_s) state_q <= PS_DOWN;
                PS_DOWN: if (pg_s) begin
                    state_q <= PS_STAB;
                    cnt_q   <= WAKE_LOAD;
                end
                default: state_q <= PS_WAIT;
            endcase
        end
    end

    assign strap   = strap_q;
    assign started = started_q;
    assign pll_on  = (state_q == PS_STAB) || (state_q == PS_RUN);
    assign running = (state_q == PS_RUN);
endmodule

// File: rtl/cfg_bank.sv
`timescale 1ns/1ps
module cfg_bank
    import clkout_pd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  strap_t             strap,
    output logic [NUM_DIF-1:0] en_vec,
    output logic [7:0]         rd0,
    output logic [7:0]         rd1,
    output logic [7:0]         rd2
);
    localparam int RDW = 8 * NUM_BYTES;

    for (genvar i = 0; i < NUM_DIF; i++) begin : g_en
        localparam en_loc_t LOC = en_loc(i);
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst)
                en_q <= 1'b1;
            else if (cfg_we && cfg_addr == LOC.byte_idx)
                en_q <= cfg_wdata[LOC.bit_idx];
        end
        assign en_vec[i] = en_q;
    end

    logic [RDW-1:0] rd_flat;

    always_comb begin
        en_loc_t loc_v;
        for (int b = 0; b < NUM_BYTES; b++)
            rd_flat[b*8 +: 8] = fixed_ones(b);
        for (int ch = 0; ch < NUM_DIF; ch++) begin
            loc_v = en_loc(ch);
            rd_flat[int'(loc_v.byte_idx) * 8 + int'(loc_v.bit_idx)] = en_vec[ch];
        end
        rd_flat[7:6] = strap.mode;
        rd_flat[0]   = strap.freq100;
    end

    assign rd0 = rd_flat[7:0];
    assign rd1 = rd_flat[15:8];
    assign rd2 = rd_flat[23:16];
endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
module out_gate #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_lvl,
    input  logic [N-1:0] want_dif,
    input  logic         want_fb,
    output logic [N-1:0] gate_dif,
    output logic         gate_fb,
    output logic [N-1:0] out_dif,
    output logic         out_fb
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic g_q;
        always_ff @(posedge clk) begin
            if (rst)           g_q <= 1'b0;
            else if (!ref_lvl) g_q <= want_dif[i];
        end
        assign gate_dif[i] = g_q;
        assign out_dif[i]  = g_q & ref_lvl;
    end

    logic fb_q;
    always_ff @(posedge clk) begin
        if (rst)           fb_q <= 1'b0;
        else if (!ref_lvl) fb_q <= want_fb;
    end
    assign gate_fb = fb_q;
    assign out_fb  = fb_q & ref_lvl;
endmodule

// File: rtl/clkout_pd_ctrl.sv
`timescale 1ns/1ps
module clkout_pd_ctrl
    import clkout_pd_pkg::*;
#(
    parameter int STAB_CYC    = 25000,
    parameter int WAKE_CYC    = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pg_pin,
    input  logic               freq_strap,
    input  logic [1:0]         mode_strap,
    input  logic               ref_lvl,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rd0,
    output logic [7:0]         cfg_rd1,
    output logic [7:0]         cfg_rd2,
    output logic               pll_on,
    output logic [NUM_DIF-1:0] dif_gate,
    output logic               fb_gate,
    output logic [NUM_DIF-1:0] dif_out,
    output logic               fb_out
);
    logic               pg_s;
    strap_t             strap_w;
    logic               started_w;
    logic               running_w;
    logic [NUM_DIF-1:0] en_w;
    logic [NUM_DIF-1:0] want_dif;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pg_pin),
        .dout(pg_s)
    );

    power_seq #(.STAB_CYC(STAB_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pg_s      (pg_s),
        .freq_strap(freq_strap),
        .mode_strap(mode_strap),
        .strap     (strap_w),
        .started   (started_w),
        .pll_on    (pll_on),
        .running   (running_w)
    );

    cfg_bank u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .strap    (strap_w),
        .en_vec   (en_w),
        .rd0      (cfg_rd0),
        .rd1      (cfg_rd1),
        .rd2      (cfg_rd2)
    );

    assign want_dif = en_w & {NUM_DIF{running_w}};

    out_gate #(.N(NUM_DIF)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .ref_lvl (ref_lvl),
        .want_dif(want_dif),
        .want_fb (running_w),
        .gate_dif(dif_gate),
        .gate_fb (fb_gate),
        .out_dif (dif_out),
        .out_fb  (fb_out)
    );
endmodule

// File: rtl/clkout_pd_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_pd_ctrl_chk #(
    parameter int N = 15
) (
    input logic         clk,
    input logic         rst,
    input logic         ref_lvl,
    input logic         pll_on,
    input logic         running,
    input logic         started,
    input logic [N-1:0] en_vec,
    input logic [N-1:0] dif_gate,
    input logic         fb_gate,
    input logic [7:0]   cfg_rd0,
    input logic [7:0]   cfg_rd1,
    input logic [7:0]   cfg_rd2
);
    // R10
    no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dif_gate) || !$stable(fb_gate)) |-> !$past(ref_lvl));

    // R5
    pd_park_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(pll_on) && !$past(ref_lvl)) |-> (dif_gate == '0 && !fb_gate));

    // R7
    dis_park_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ref_lvl) |-> ((dif_gate & ~$past(en_vec)) == '0));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(started) |-> ($stable(cfg_rd0[7:6]) && $stable(cfg_rd0[0])));

    // R4
    run_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fb_gate) |-> $past(running));

    // R9
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd0[5] && cfg_rd0[2:1] == 2'b00 && cfg_rd1[6] && cfg_rd1[0] && cfg_rd2[4]);
endmodule

bind clkout_pd_ctrl clkout_pd_ctrl_chk #(.N(clkout_pd_pkg::NUM_DIF)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ref_lvl (ref_lvl),
    .pll_on  (pll_on),
    .running (running_w),
    .started (started_w),
    .en_vec  (en_w),
    .dif_gate(dif_gate),
    .fb_gate (fb_gate),
    .cfg_rd0 (cfg_rd0),
    .cfg_rd1 (cfg_rd1),
    .cfg_rd2 (cfg_rd2)
);

// File: tb/clkout_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkout_pd_ctrl_tb_top;
    localparam int STAB = 20;
    localparam int WAKE = 8;
    localparam int WD_CYC = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg_pin = 1'b0;
    logic        freq_strap = 1'b1;
    logic [1:0]  mode_strap = 2'b10;
    logic        ref_lvl = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rd0, cfg_rd1, cfg_rd2;
    logic        pll_on, fb_gate, fb_out;
    logic [14:0] dif_gate, dif_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkout_pd_ctrl #(.STAB_CYC(STAB), .WAKE_CYC(WAKE)) dut_i (
        .clk(clk), .rst(rst), .pg_pin(pg_pin), .freq_strap(freq_strap),
        .mode_strap(mode_strap), .ref_lvl(ref_lvl), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rd0(cfg_rd0),
        .cfg_rd1(cfg_rd1), .cfg_rd2(cfg_rd2), .pll_on(pll_on),
        .dif_gate(dif_gate), .fb_gate(fb_gate), .dif_out(dif_out), .fb_out(fb_out)
    );

    // write vectors: {addr, wdata, rd0, rd1, rd2} before start-up
    localparam logic [33:0] VEC [7] = '{
        {2'd1, 8'h00, 8'h38, 8'h41, 8'hFF},
        {2'd2, 8'h00, 8'h38, 8'h41, 8'h10},
        {2'd0, 8'h00, 8'h20, 8'h41, 8'h10},
        {2'd3, 8'h00, 8'h20, 8'h41, 8'h10},
        {2'd0, 8'hFF, 8'h38, 8'h41, 8'h10},
        {2'd1, 8'hFF, 8'h38, 8'hFF, 8'h10},
        {2'd2, 8'hFF, 8'h38, 8'hFF, 8'hFF}
    };

    // enable location per output: {byte, bit}
    localparam logic [4:0] MAP [15] = '{
        5'b01_001, 5'b01_010, 5'b01_011, 5'b01_100, 5'b01_101, 5'b01_111,
        5'b10_000, 5'b10_001, 5'b10_010, 5'b10_011, 5'b10_101, 5'b10_110,
        5'b10_111, 5'b00_011, 5'b00_100
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 gates in reset", {16'h0, fb_gate, dif_gate}, 32'h0);
        rst = 1'b0;
        tick(1);
        chk("R1 gates", {16'h0, fb_gate, dif_gate}, 32'h0);
        chk("R11 pll_on before start", {31'h0, pll_on}, 32'h0);
        chk("R1 readback", {8'h0, cfg_rd2, cfg_rd1, cfg_rd0}, 32'h00FFFF38);

        // R8 R9 write vectors
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][33:32], VEC[i][31:24]);
            chk("R9 R8 vector readback", {8'h0, cfg_rd2, cfg_rd1, cfg_rd0},
                {8'h0, VEC[i][7:0], VEC[i][15:8], VEC[i][23:16]});
        end

        // R2 R4 R11 cold start
        pg_pin = 1'b1;
        tick(2);
        chk("R4 pll_on still off", {31'h0, pll_on}, 32'h0);
        tick(1);
        chk("R11 pll_on in stabilization", {31'h0, pll_on}, 32'h1);
        chk("R2 latched straps", {24'h0, cfg_rd0}, 32'h79);
        tick(STAB);
        chk("R4 parked at end of wait", {16'h0, fb_gate, dif_gate}, 32'h0);
        tick(1);
        chk("R4 running", {16'h0, fb_gate, dif_gate}, 32'hFFFF);

        // R3 strap changes ignored
        freq_strap = 1'b0; mode_strap = 2'b00;
        tick(5);
        chk("R3 straps held", {24'h0, cfg_rd0}, 32'h79);

        // R7 R8 per-output disable
        for (int ch = 0; ch < 15; ch++) begin
            wr(MAP[ch][4:3], ~(8'h01 << MAP[ch][2:0]));
            tick(1);
            chk("R7 R8 single disable", {16'h0, fb_gate, dif_gate},
                {16'h0, 1'b1, 15'h7FFF & ~(15'h1 << ch)});
            wr(MAP[ch][4:3], 8'hFF);
            tick(1);
        end

        // R10 no change while reference high
        ref_lvl = 1'b1;
        wr(2'd1, 8'h00);
        tick(3);
        chk("R10 gate held while high", {17'h0, dif_gate}, 32'h7FFF);
        chk("R10 out follows ref", {16'h0, fb_out, dif_out}, 32'hFFFF);
        ref_lvl = 1'b0;
        tick(1);
        chk("R10 gate updates when low", {17'h0, dif_gate}, 32'h7FC0);
        chk("R10 out low with ref", {16'h0, fb_out, dif_out}, 32'h0);
        wr(2'd1, 8'hFF);
        tick(1);

        // R5 power-down
        pg_pin = 1'b0;
        tick(3);
        chk("R5 pll off", {31'h0, pll_on}, 32'h0);
        tick(1);
        chk("R5 all parked", {16'h0, fb_gate, dif_gate}, 32'h0);
        ref_lvl = 1'b1;
        tick(2);
        chk("R5 outputs low", {16'h0, fb_out, dif_out}, 32'h0);
        ref_lvl = 1'b0;
        tick(1);

        // R6 wake-up with short wait, R3 straps still held
        pg_pin = 1'b1;
        tick(3);
        chk("R11 pll on at wake", {31'h0, pll_on}, 32'h1);
        tick(WAKE);
        chk("R6 parked at end of wake wait", {16'h0, fb_gate, dif_gate}, 32'h0);
        tick(1);
        chk("R6 running after wake", {16'h0, fb_gate, dif_gate}, 32'hFFFF);
        chk("R3 straps after wake", {24'h0, cfg_rd0}, 32'h79);

        // R1 second reset clears everything
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R1 gates after reset", {15'h0, pll_on, fb_gate, dif_gate}, 32'h0);
        chk("R1 readback after reset", {8'h0, cfg_rd2, cfg_rd1, cfg_rd0}, 32'h00FFFF38);

        done = 1'b1;
        finish_run();
    end
endmodule